// File: doc/BRIEF.md
# SD Card Bring-Up Sequencer

This block is the host-side controller that takes an SD memory card from power-up to the data transfer state over the SD bus. It does not serialise anything itself. It presents each command as an index and a 32-bit argument with a one-cycle start strobe, and it consumes parsed replies as a valid strobe with a 32-bit payload. It counts its own response timeouts.

A `start` pulse launches the whole sequence. The order is: a quiet pre-clock stage, the reset command, an interface check with echo verification, and repeated operating-condition polling. An optional low-voltage signalling switch follows, then identification, address assignment, selection, an unlock step when the card reports itself locked, and the 4-bit bus-width change. When the sequence ends, `done` rises and holds. With it the block presents four results: the latched high-capacity and low-voltage-accepted flags, the card address, and a 4-bit result code. A new `start` at any time abandons the current run and begins again from the quiet stage.

Top module: `sd_bringup_seq`

## Requirements
- R1: After `start`, `cmd_start` stays low for at least PRE_CLKS cycles (default 74). The first command issued is index 0 with argument 0.
- R2: The command right after index 0 is index 8, with argument {20'b0, SUPPLY_CODE, CHECK_PATTERN} (0x1A5 by default). No index 41 is issued before it.
- R3: The low 12 bits of the index 8 reply must equal the 12 bits sent. A mismatch ends with code 2. No reply within RESP_TIMEOUT cycles ends with code 1. No command follows either outcome.
- R4: Each index 41 command is preceded by index 55 and always carries 0x41FF8000. Polling continues while reply bit 31 is 0. A POLL_MAX-th not-ready reply ends with code 3, after exactly POLL_MAX index 41 commands.
- R5: `high_cap` and `low_volt_ok` take reply bits 30 and 24 only from the first reply that has bit 31 set. Not-ready replies leave them at 0.
- R6: Index 11 is issued only when `low_volt_ok` is 1. After its reply, `volt_sw_req` stays high until `dat_level` reads 4'hF, and then index 2 follows. No reply to index 11 gives code 4. DAT lines not high within RESP_TIMEOUT cycles give code 5.
- R7: Index 2 (argument 0) is followed by index 3 (argument 0). Reply bits 31:16 of index 3 become `card_addr`. A zero address ends with code 6.
- R8: Index 7 carries {card_addr, 16'h0}. When bit 25 of its reply is 1, index 42 (argument 0) is issued next while `bus_4bit` is still 0. Otherwise index 42 is skipped.
- R9: The sequence ends with index 55 carrying {card_addr, 16'h0}, then index 6 with argument 2. Once index 6 is answered, `bus_4bit` becomes 1 and `done` rises with code 0.
- R10: A missing reply to index 2, 3, 7, 42, 55 or 41 within RESP_TIMEOUT cycles ends with code 7.
- R11: After reset, and after any `start`, all outputs are 0. `done` and the results hold with `busy` low and no command until the next `start`. A `start` during a run restarts from the quiet stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin or restart the bring-up sequence |
| cmd_start | output | 1 | One-cycle strobe: issue the command now |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Parsed reply present this cycle |
| rsp_data | input | 32 | Reply payload (status, OCR, address or echo) |
| dat_level | input | 4 | Sampled DAT[3:0] levels |
| volt_sw_req | output | 1 | Signalling-voltage switch requested, waiting for DAT high |
| bus_4bit | output | 1 | Card has been switched to the 4-bit bus |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished (success or failure) |
| high_cap | output | 1 | Latched high-capacity flag |
| low_volt_ok | output | 1 | Latched low-voltage-accepted flag |
| card_addr | output | 16 | Latched card address |
| err_code | output | 4 | Result code: 0 ok, 1 no voltage, 2 echo, 3 poll limit, 4 switch, 5 DAT, 6 zero address, 7 timeout |

## Verification
The first command strobe appears exactly PRE_CLKS cycles after the edge that samples `start`. The bench timestamps that edge and the first strobe it sees, and requires the distance to be exactly PRE_CLKS. A reply is consumed on the edge that samples it, and the next command strobe comes one cycle later. Index 0 is followed by index 8 with no gap, and a missing reply ends the run RESP_TIMEOUT cycles after the strobe. All stimulus and sampling happen on falling edges. A card model in the bench logs every strobed command and answers two cycles later, and the bench waits for `done` before comparing the ordered log, result code and latched fields against a sequence it computes from the card model's configuration.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;

  typedef enum logic [3:0] {
    ST_RST, ST_IFC, ST_P55, ST_OPC, ST_VSW, ST_DAT,
    ST_CID, ST_ADR, ST_SEL, ST_UNL, ST_B55, ST_BUS
  } step_t;

  typedef enum logic [1:0] {PH_IDLE, PH_PRE, PH_ISSUE, PH_WAIT} phase_t;

  localparam logic [3:0] E_NONE   = 4'd0;
  localparam logic [3:0] E_NOVOLT = 4'd1;
  localparam logic [3:0] E_ECHO   = 4'd2;
  localparam logic [3:0] E_POLL   = 4'd3;
  localparam logic [3:0] E_VSW    = 4'd4;
  localparam logic [3:0] E_DAT    = 4'd5;
  localparam logic [3:0] E_ADDR0  = 4'd6;
  localparam logic [3:0] E_TMO    = 4'd7;

  // capacity request bit 30, low-voltage request bit 24, voltage window 23:15
  localparam logic [31:0] OPC_ARG  = 32'h41FF_8000;
  localparam logic [31:0] WIDE_ARG = 32'h0000_0002;

  function automatic logic [5:0] step_index(step_t s);
    case (s)
      ST_IFC:         return 6'd8;
      ST_P55, ST_B55: return 6'd55;
      ST_OPC:         return 6'd41;
      ST_VSW:         return 6'd11;
      ST_CID:         return 6'd2;
      ST_ADR:         return 6'd3;
      ST_SEL:         return 6'd7;
      ST_UNL:         return 6'd42;
      ST_BUS:         return 6'd6;
      default:        return 6'd0;
    endcase
  endfunction

  function automatic logic [3:0] timeout_code(step_t s);
    case (s)
      ST_IFC:  return E_NOVOLT;
      ST_VSW:  return E_VSW;
      ST_DAT:  return E_DAT;
      default: return E_TMO;
    endcase
  endfunction

  function automatic logic echo_match(logic [31:0] rsp, logic [11:0] sent);
    return rsp[11:0] == sent;
  endfunction

  function automatic logic [31:0] addr_arg(logic [15:0] a);
    return {a, 16'h0000};
  endfunction

endpackage

// File: rtl/sd_init_timer.sv
module sd_init_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic          hit
);
  timeunit 1ns; timeprecision 1ps;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + 1'b1;
  end

  assign hit = en && (cnt == limit - 1'b1);
endmodule

// File: rtl/sd_init_cmdgen.sv
module sd_init_cmdgen
  import sd_init_pkg::*;
#(
  parameter logic [3:0] SUPPLY_CODE   = 4'h1,
  parameter logic [7:0] CHECK_PATTERN = 8'hA5
) (
  input  step_t       step,
  input  logic [15:0] addr,
  output logic [5:0]  idx,
  output logic [31:0] arg
);
  timeunit 1ns; timeprecision 1ps;

  localparam logic [31:0] IFC_ARG = {20'h0, SUPPLY_CODE, CHECK_PATTERN};

  assign idx = step_index(step);

  always_comb begin
    case (step)
      ST_IFC:         arg = IFC_ARG;
      ST_OPC:         arg = OPC_ARG;
      ST_SEL, ST_B55: arg = addr_arg(addr);
      ST_BUS:         arg = WIDE_ARG;
      default:        arg = 32'h0;
    endcase
  end
endmodule

// File: rtl/sd_bringup_seq.sv
module sd_bringup_seq
  import sd_init_pkg::*;
#(
  parameter int          PRE_CLKS      = 74,
  parameter int          RESP_TIMEOUT  = 1024,
  parameter int          POLL_MAX      = 1000,
  parameter logic [3:0]  SUPPLY_CODE   = 4'h1,
  parameter logic [7:0]  CHECK_PATTERN = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        cmd_start,
  output logic [5:0]  cmd_index,
  output logic [31:0] cmd_arg,
  input  logic        rsp_valid,
  input  logic [31:0] rsp_data,
  input  logic [3:0]  dat_level,
  output logic        volt_sw_req,
  output logic        bus_4bit,
  output logic        busy,
  output logic        done,
  output logic        high_cap,
  output logic        low_volt_ok,
  output logic [15:0] card_addr,
  output logic [3:0]  err_code
);
  timeunit 1ns; timeprecision 1ps;

  localparam int TW_MAX = (PRE_CLKS > RESP_TIMEOUT) ? PRE_CLKS : RESP_TIMEOUT;
  localparam int CW = $clog2(TW_MAX + 1);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam logic [11:0] IFC_SENT = {SUPPLY_CODE, CHECK_PATTERN};

  phase_t        phase;
  step_t         step;
  logic [PW-1:0] polls;

  // named internal events
  logic          wait_ok, wait_tmo, tmr_clr, tmr_en, tmr_hit;
  logic [CW-1:0] tmr_limit;
  logic          ocr_ready, poll_last, addr_zero, lock_seen, rsp_unused;

  assign wait_ok   = (phase == PH_WAIT) && ((step == ST_DAT) ? (&dat_level) : rsp_valid);
  assign wait_tmo  = (phase == PH_WAIT) && !wait_ok && tmr_hit;
  assign tmr_clr   = start || (phase == PH_ISSUE) || wait_ok;
  assign tmr_en    = (phase == PH_PRE) || (phase == PH_WAIT);
  assign tmr_limit = (phase == PH_PRE) ? CW'(PRE_CLKS) : CW'(RESP_TIMEOUT);
  assign ocr_ready = rsp_data[31];
  assign poll_last = (polls == PW'(POLL_MAX - 1));
  assign addr_zero = (rsp_data[31:16] == 16'h0);
  assign lock_seen = rsp_data[25];
  assign rsp_unused = ^rsp_data;

  assign cmd_start   = (phase == PH_ISSUE);
  assign busy        = (phase != PH_IDLE);
  assign volt_sw_req = (phase == PH_WAIT) && (step == ST_DAT);

  sd_init_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .en    (tmr_en),
    .limit (tmr_limit),
    .hit   (tmr_hit)
  );

  sd_init_cmdgen #(.SUPPLY_CODE(SUPPLY_CODE), .CHECK_PATTERN(CHECK_PATTERN)) u_cmdgen (
    .step (step),
    .addr (card_addr),
    .idx  (cmd_index),
    .arg  (cmd_arg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;  step <= ST_RST;  polls <= '0;
      done <= 1'b0;  err_code <= E_NONE;  high_cap <= 1'b0;
      low_volt_ok <= 1'b0;  card_addr <= 16'h0;  bus_4bit <= 1'b0;
    end else if (start) begin
      phase <= PH_PRE;  step <= ST_RST;  polls <= '0;
      done <= 1'b0;  err_code <= E_NONE;  high_cap <= 1'b0;
      low_volt_ok <= 1'b0;  card_addr <= 16'h0;  bus_4bit <= 1'b0;
    end else begin
      case (phase)
        PH_PRE: if (tmr_hit) phase <= PH_ISSUE;
        PH_ISSUE: begin
          // the reset command has no reply: go straight on to the interface check
          if (step == ST_RST) step <= ST_IFC;
          else                phase <= PH_WAIT;
        end
        PH_WAIT: begin
          if (wait_ok) begin
            phase <= PH_ISSUE;
            case (step)
              ST_IFC: begin
                if (echo_match(rsp_data, IFC_SENT)) step <= ST_P55;
                else begin phase <= PH_IDLE; done <= 1'b1; err_code <= E_ECHO; end
              end
              ST_P55: step <= ST_OPC;
              ST_OPC: begin
                if (ocr_ready) begin
                  high_cap    <= rsp_data[30];
                  low_volt_ok <= rsp_data[24];
                  step        <= rsp_data[24] ? ST_VSW : ST_CID;
                end else if (poll_last) begin
                  phase <= PH_IDLE; done <= 1'b1; err_code <= E_POLL;
                end else begin
                  polls <= polls + 1'b1;
                  step  <= ST_P55;
                end
              end
              ST_VSW: begin step <= ST_DAT; phase <= PH_WAIT; end
              ST_DAT: step <= ST_CID;
              ST_CID: step <= ST_ADR;
              ST_ADR: begin
                if (addr_zero) begin
                  phase <= PH_IDLE; done <= 1'b1; err_code <= E_ADDR0;
                end else begin
                  card_addr <= rsp_data[31:16];
                  step      <= ST_SEL;
                end
              end
              ST_SEL: step <= lock_seen ? ST_UNL : ST_B55;
              ST_UNL: step <= ST_B55;
              ST_B55: step <= ST_BUS;
              ST_BUS: begin
                bus_4bit <= 1'b1; phase <= PH_IDLE; done <= 1'b1; err_code <= E_NONE;
              end
              default: begin phase <= PH_IDLE; done <= 1'b1; err_code <= E_TMO; end
            endcase
          end else if (wait_tmo) begin
            phase <= PH_IDLE; done <= 1'b1; err_code <= timeout_code(step);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sd_bringup_chk.sv
module sd_bringup_chk #(
  parameter int PRE_CLKS = 74
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        cmd_start,
  input logic [5:0]  cmd_index,
  input logic        volt_sw_req,
  input logic        bus_4bit,
  input logic        busy,
  input logic        done,
  input logic        low_volt_ok,
  input logic [15:0] card_addr,
  input logic [3:0]  err_code
);
  timeunit 1ns; timeprecision 1ps;

  localparam int SW = $clog2(PRE_CLKS + 1);

  logic [SW-1:0] since_start;
  logic [5:0]    last_idx;
  logic          seen_ifc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_start <= SW'(PRE_CLKS);
      last_idx    <= 6'd0;
      seen_ifc    <= 1'b0;
    end else if (start) begin
      since_start <= '0;
      last_idx    <= 6'd0;
      seen_ifc    <= 1'b0;
    end else begin
      if (since_start < SW'(PRE_CLKS)) since_start <= since_start + 1'b1;
      if (cmd_start) begin
        last_idx <= cmd_index;
        if (cmd_index == 6'd8) seen_ifc <= 1'b1;
      end
    end
  end

  AST_PRE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> (since_start >= SW'(PRE_CLKS))); // R1
  AST_IFC_BEFORE_OPC: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_index == 6'd41) |-> seen_ifc); // R2
  AST_APP_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && (cmd_index == 6'd41 || cmd_index == 6'd6)) |-> (last_idx == 6'd55)); // R4
  AST_VSW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_index == 6'd11) |-> low_volt_ok); // R6
  AST_VSW_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    volt_sw_req |-> (low_volt_ok && busy && !cmd_start)); // R6
  AST_UNLOCK_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_index == 6'd42) |-> !bus_4bit); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !cmd_start)); // R11
  AST_OK_HAS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 4'd0) |-> (card_addr != 16'h0 && bus_4bit)); // R7
endmodule

bind sd_bringup_seq sd_bringup_chk #(.PRE_CLKS(PRE_CLKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .cmd_start   (cmd_start),
  .cmd_index   (cmd_index),
  .volt_sw_req (volt_sw_req),
  .bus_4bit    (bus_4bit),
  .busy        (busy),
  .done        (done),
  .low_volt_ok (low_volt_ok),
  .card_addr   (card_addr),
  .err_code    (err_code)
);

// File: tb/tb_sd_bringup_seq.sv
module tb_sd_bringup_seq;
  timeunit 1ns; timeprecision 1ps;

  localparam int PRE  = 74;
  localparam int TMO  = 16;
  localparam int PMAX = 4;
  localparam logic [31:0] OPC = 32'h41FF_8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rsp_valid = 1'b0;
  logic [31:0] rsp_data = 32'h0;
  logic [3:0] dat_level = 4'h0;

  logic        cmd_start, volt_sw_req, bus_4bit, busy, done, high_cap, low_volt_ok;
  logic [5:0]  cmd_index;
  logic [31:0] cmd_arg;
  logic [15:0] card_addr;
  logic [3:0]  err_code;

  always #4 clk = ~clk;  // 8 ns period

  sd_bringup_seq #(.PRE_CLKS(PRE), .RESP_TIMEOUT(TMO), .POLL_MAX(PMAX)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmd_start(cmd_start), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .dat_level(dat_level),
    .volt_sw_req(volt_sw_req), .bus_4bit(bus_4bit), .busy(busy), .done(done),
    .high_cap(high_cap), .low_volt_ok(low_volt_ok), .card_addr(card_addr),
    .err_code(err_code)
  );

  // card model configuration
  int          c_busy, c_echo, c_silent, poll_n;
  bit          c_ccs, c_s18a, c_lock, c_dat_ok;
  logic [15:0] c_rca;

  // command log and expectation
  logic [5:0]  log_idx [64];
  logic [31:0] log_arg [64];
  int          log_n;
  longint      t_start, t_first;
  logic [5:0]  exp_idx [64];
  logic [31:0] exp_arg [64];
  int          exp_n;
  logic [3:0]  exp_err;
  bit          exp_ccs, exp_s18a, exp_bus4, stop;
  logic [15:0] exp_rca;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] reply(input logic [5:0] idx, input logic [31:0] arg, input int pn);
    case (idx)
      6'd8: begin
        if (c_echo == 1)      return {20'h0, arg[11:8], arg[7:0] ^ 8'hFF};
        else if (c_echo == 2) return {20'h0, arg[11:8] ^ 4'h3, arg[7:0]};
        else                  return {20'h0, arg[11:0]};
      end
      6'd41: return (pn < c_busy) ? 32'h41FF_8000 : {1'b1, c_ccs, 5'b0, c_s18a, 24'hFF8000};
      6'd3:  return {c_rca, 16'h0500};
      6'd7:  return c_lock ? 32'h0200_0900 : 32'h0000_0900;
      default: return 32'h0000_0900;
    endcase
  endfunction

  // card model: logs each strobed command and answers two cycles later
  initial begin
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (cmd_start) begin
        automatic logic [5:0]  ci = cmd_index;
        automatic logic [31:0] ca = cmd_arg;
        automatic logic [31:0] d;
        if (log_n == 0) t_first = $time;
        if (log_n < 64) begin log_idx[log_n] = ci; log_arg[log_n] = ca; end
        log_n++;
        d = reply(ci, ca, poll_n);
        if (ci == 6'd41) poll_n++;
        if (ci != 6'd0 && int'(ci) != c_silent) begin
          repeat (2) @(negedge clk);
          rsp_valid = 1'b1;
          rsp_data  = d;
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      dat_level = (c_dat_ok && volt_sw_req) ? 4'hF : 4'h0;
    end
  end

  task automatic push(input logic [5:0] idx, input logic [31:0] arg);
    if (exp_n < 64) begin exp_idx[exp_n] = idx; exp_arg[exp_n] = arg; end
    exp_n++;
    if (int'(idx) == c_silent) begin
      stop = 1;
      exp_err = (idx == 6'd8) ? 4'd1 : (idx == 6'd11) ? 4'd4 : 4'd7;
    end
  endtask

  task automatic build_expect();
    bit ready;
    exp_n = 0; stop = 0; exp_err = 4'd0; exp_ccs = 0; exp_s18a = 0; exp_bus4 = 0; exp_rca = 16'h0;
    push(6'd0, 32'h0);
    push(6'd8, 32'h0000_01A5);
    if (!stop && c_echo != 0) begin stop = 1; exp_err = 4'd2; end
    ready = 0;
    for (int p = 0; p < PMAX && !stop && !ready; p++) begin
      push(6'd55, 32'h0);
      if (!stop) push(6'd41, OPC);
      if (!stop && p >= c_busy) ready = 1;
    end
    if (!stop && !ready) begin stop = 1; exp_err = 4'd3; end
    if (!stop) begin exp_ccs = c_ccs; exp_s18a = c_s18a; end
    if (!stop && c_s18a) begin
      push(6'd11, 32'h0);
      if (!stop && !c_dat_ok) begin stop = 1; exp_err = 4'd5; end
    end
    if (!stop) push(6'd2, 32'h0);
    if (!stop) push(6'd3, 32'h0);
    if (!stop && c_rca == 16'h0) begin stop = 1; exp_err = 4'd6; end
    if (!stop) exp_rca = c_rca;
    if (!stop) push(6'd7, {c_rca, 16'h0});
    if (!stop && c_lock) push(6'd42, 32'h0);
    if (!stop) push(6'd55, {c_rca, 16'h0});
    if (!stop) push(6'd6, 32'h2);
    if (!stop) exp_bus4 = 1;
  endtask

  task automatic set_card(input int busyp, input bit ccs, input bit s18a, input int echo,
                          input bit lock, input bit dat_ok, input logic [15:0] rca, input int silent);
    c_busy = busyp; c_ccs = ccs; c_s18a = s18a; c_echo = echo;
    c_lock = lock; c_dat_ok = dat_ok; c_rca = rca; c_silent = silent;
  endtask

  task automatic do_start();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    t_start = $time;
    #1;
    log_n = 0; poll_n = 0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_case(input string tag);
    int w;
    int mism;
    int n0;
    do_start();
    w = 0;
    while (!done && w < 5000) begin @(negedge clk); w++; end
    build_expect();
    chk(tag, "finished", {31'b0, done}, 32'h1);
    chk(tag, "result code", {28'h0, err_code}, {28'h0, exp_err});
    chk(tag, "command count", log_n, exp_n);
    mism = 0;
    for (int i = 0; i < exp_n && i < log_n && i < 64; i++)
      if (log_idx[i] !== exp_idx[i] || log_arg[i] !== exp_arg[i]) mism++;
    chk(tag, "command order/arguments mismatches", mism, 0);
    chk("R1", "quiet cycles before first command", int'((t_first - t_start - 4) / 8), PRE);
    chk("R5", "high_cap", {31'b0, high_cap}, {31'b0, exp_ccs});
    chk("R5", "low_volt_ok", {31'b0, low_volt_ok}, {31'b0, exp_s18a});
    chk("R7", "card_addr", {16'h0, card_addr}, {16'h0, exp_rca});
    chk("R9", "bus_4bit", {31'b0, bus_4bit}, {31'b0, exp_bus4});
    n0 = log_n;
    repeat (10) @(negedge clk);
    chk("R11", "done held, idle, no further command",
        {29'b0, done, busy, 1'b0} | ((log_n != n0) ? 32'h1 : 32'h0), 32'h4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    set_card(0, 1, 0, 0, 0, 1, 16'h1234, 63);
    log_n = 0; poll_n = 0; t_first = 0; t_start = 0;
    repeat (3) @(negedge clk);
    chk("R11", "reset outputs",
        {cmd_start, volt_sw_req, bus_4bit, busy, done, high_cap, low_volt_ok, err_code, card_addr}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11", "idle after reset", {30'b0, busy, done}, 32'h0);

    set_card(0, 1, 0, 0, 0, 1, 16'h1234, 63);  run_case("R2");   // plain bring-up
    set_card(2, 0, 1, 0, 1, 1, 16'hBEEF, 63);  run_case("R8");   // busy polls, switch, locked
    set_card(0, 1, 0, 1, 0, 1, 16'h1234, 63);  run_case("R3");   // pattern not echoed
    set_card(0, 1, 0, 2, 0, 1, 16'h1234, 63);  run_case("R3");   // voltage field not echoed
    set_card(0, 1, 0, 0, 0, 1, 16'h1234, 8);   run_case("R3");   // no interface reply
    set_card(10, 1, 0, 0, 0, 1, 16'h1234, 63); run_case("R4");   // poll limit
    set_card(3, 1, 0, 0, 0, 1, 16'h0042, 63);  run_case("R4");   // ready on last allowed poll
    set_card(0, 1, 1, 0, 0, 1, 16'h7001, 11);  run_case("R6");   // switch command unanswered
    set_card(0, 0, 1, 0, 0, 0, 16'h7001, 63);  run_case("R6");   // DAT never high
    set_card(0, 1, 1, 0, 0, 1, 16'h7001, 63);  run_case("R6");   // successful switch
    set_card(0, 1, 0, 0, 0, 1, 16'h0000, 63);  run_case("R7");   // zero address
    set_card(0, 1, 0, 0, 0, 1, 16'h2222, 7);   run_case("R10");  // select unanswered
    set_card(1, 1, 0, 0, 1, 1, 16'h2222, 42);  run_case("R10");  // unlock unanswered
    set_card(0, 0, 0, 0, 0, 1, 16'hA5A5, 63);  run_case("R9");   // low capacity, no lock

    // restart in the middle of a run
    set_card(1, 1, 0, 0, 1, 1, 16'h3333, 63);
    do_start();
    repeat (90) @(negedge clk);
    chk("R11", "busy mid-run", {31'b0, busy}, 32'h1);
    run_case("R11");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule